// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Matcher

This block is the receive-side front end of a slave on a two-wire serial bus (SMBus / I2C). It samples the clock and data lines through synchronisers, detects START and STOP, shifts in the first byte after each START (seven address bits, then the read/write flag), and decides whether to acknowledge. The acknowledge decision comes from one of two places. In automatic mode, the incoming address is compared with a programmable slave address under a per-bit mask, and the general call address may optionally be accepted. In host mode, the decision is a level supplied by the host for every byte.

After an acknowledged write address, the block keeps receiving data bytes. It hands each data byte to the host with a one-cycle strobe. In automatic mode it also acknowledges each data byte by itself. A refused address or byte sends the block into a quiet state until the next START. A STOP returns it to idle. Clock stretching and transmission of read data are not part of the block: after a read address it releases the bus.

Top module: `smb_addr_match`

## Requirements
- R1: Two write-only configuration words are selected by `cfg_sel`. Word 0 holds the slave address in bits [6:0] and the general-call enable in bit 7. Word 1 holds the compare mask in bits [6:0] and the automatic-acknowledge enable in bit 7. After reset the address is 0, both enables are 0 and the mask is all ones. All status outputs and `sda_pull` are 0 after reset.
- R2: With automatic acknowledge on, an address byte is acknowledged when, for every mask bit that is 1, the incoming address bit equals the slave address bit. Bits whose mask is 0 match either value. The address field 0 never matches through this compare.
- R3: With automatic acknowledge on, address field 0 is acknowledged exactly when the general-call enable is 1.
- R4: An acknowledge is given by asserting `sda_pull` (1 = hold SDA low). The pull starts after the eighth falling SCL edge, is held through the ninth SCL high phase, and is released after the ninth falling edge. `sda_pull` never changes while SCL stays high.
- R5: With automatic acknowledge off, no address compare is made. `byte_rdy` pulses once after the eighth bit of every received byte, address bytes included. The acknowledge on the ninth clock equals the `host_ack` level present before the ninth rising SCL edge (1 = ACK).
- R6: After the ninth falling edge of an acknowledged address byte, `addr_hit` is 1, `dir_read` equals the received R/W bit (bit 0 of the byte, 1 = read), and `gen_call` is 1 exactly when the address field was 0.
- R7: For each data byte of an acknowledged write, `rx_strobe` pulses once and `rx_byte` holds the byte, received MSB first. In automatic mode each such byte is acknowledged.
- R8: After a refused address or data byte, the block drives no pull and gives no strobe until the next START.
- R9: START (SDA falls while SCL is high) begins a new address phase and clears `addr_hit`, including a repeated START. STOP (SDA rises while SCL is high) returns the block to idle with `addr_hit` 0.
- R10: After an acknowledged read address, the block releases SDA and neither acknowledges nor strobes until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = address word, 1 = mask word |
| cfg_wdata | input | 8 | Configuration write data |
| host_ack | input | 1 | Host acknowledge decision in host mode (1 = ACK) |
| addr_hit | output | 1 | Block is addressed |
| dir_read | output | 1 | R/W bit of the accepted address |
| gen_call | output | 1 | Accepted address was the general call |
| byte_rdy | output | 1 | Host-mode pulse: eight bits received |
| rx_strobe | output | 1 | Pulse: data byte of a write received |
| rx_byte | output | 8 | Last byte shifted in |

## Verification
The hardest situation to reach is a masked compare that accepts a whole family of addresses while the general call and the exclusion of field 0 interact. The stimulus reaches it by sweeping all 128 address values under four configurations: full mask, a partial mask with general call, a sparse mask, and host mode with a host decision that varies with the address. The acknowledge seen on the wire and the status after the byte are compared with a value computed from the mask arithmetic. A repeated START after an accepted write, and a refused data byte in host mode, are driven in directed sequences. These check that the block really goes quiet and that a new address phase really begins.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_AACK = 3'd2,
    ST_DATA = 3'd3,
    ST_DACK = 3'd4,
    ST_SKIP = 3'd5
  } smb_state_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic prev
);
  logic [STAGES:0] pipe_q, pipe_n;

  always_comb pipe_n = {pipe_q[STAGES-1:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_n;
  end

  assign lvl  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          sel,
  input  logic [AW:0]   wdata,
  output logic [AW-1:0] slv_addr,
  output logic          gc_en,
  output logic [AW-1:0] slv_mask,
  output logic          hw_en
);
  logic [AW-1:0] addr_q, addr_n, mask_q, mask_n;
  logic          gc_q, gc_n, hw_q, hw_n;

  always_comb begin
    addr_n = addr_q;
    gc_n   = gc_q;
    mask_n = mask_q;
    hw_n   = hw_q;
    if (wr && !sel) {gc_n, addr_n} = wdata;
    if (wr && sel)  {hw_n, mask_n} = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      gc_q   <= 1'b0;
      mask_q <= '1;
      hw_q   <= 1'b0;
    end else begin
      addr_q <= addr_n;
      gc_q   <= gc_n;
      mask_q <= mask_n;
      hw_q   <= hw_n;
    end
  end

  assign slv_addr = addr_q;
  assign gc_en    = gc_q;
  assign slv_mask = mask_q;
  assign hw_en    = hw_q;
endmodule

// File: rtl/smb_addr_cmp.sv
module smb_addr_cmp #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] slv,
  input  logic [AW-1:0] msk,
  input  logic          gc_en,
  output logic          cmp_hit,
  output logic          gc_hit
);
  logic is_zero;
  always_comb begin
    is_zero = (addr == '0);
    cmp_hit = !is_zero && (((addr ^ slv) & msk) == '0);
    gc_hit  = gc_en && is_zero;
  end
endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match
  import smb_pkg::*;
#(
  parameter int AW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_pull,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [AW:0] cfg_wdata,
  input  logic        host_ack,
  output logic        addr_hit,
  output logic        dir_read,
  output logic        gen_call,
  output logic        byte_rdy,
  output logic        rx_strobe,
  output logic [AW:0] rx_byte
);
  localparam int DW = AW + 1;
  localparam int CW = $clog2(DW + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic scl_lvl, scl_prev, sda_lvl, sda_prev;
  smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_i_n), .d(scl_in), .lvl(scl_lvl), .prev(scl_prev));
  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_i_n), .d(sda_in), .lvl(sda_lvl), .prev(sda_prev));

  logic [AW-1:0] slv_addr, slv_mask;
  logic          gc_en, hw_en;
  smb_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .slv_addr(slv_addr), .gc_en(gc_en), .slv_mask(slv_mask), .hw_en(hw_en));

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

  smb_state_t    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          pull_q, pull_n, acked_q, acked_n;
  logic          hit_q, hit_n, dir_q, dir_n, gc_q, gc_n;
  logic          stb_q, stb_n, rdy_q, rdy_n;
  logic          cmp_hit, gc_hit;

  smb_addr_cmp #(.AW(AW)) u_cmp (
    .addr(sh_q[DW-1:1]), .slv(slv_addr), .msk(slv_mask), .gc_en(gc_en),
    .cmp_hit(cmp_hit), .gc_hit(gc_hit));

  always_comb begin
    logic ack_bit;
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    acked_n = acked_q;
    hit_n   = hit_q;
    dir_n   = dir_q;
    gc_n    = gc_q;
    stb_n   = 1'b0;
    rdy_n   = 1'b0;
    unique case (state_q)
      ST_ADDR, ST_DATA: begin
        if (scl_rise) begin
          sh_n  = {sh_q[DW-2:0], sda_lvl};
          cnt_n = cnt_q + CW'(1);
          if (cnt_q == CW'(DW - 1)) begin
            rdy_n = !hw_en;
            stb_n = (state_q == ST_DATA);
          end
        end else if (scl_fall && cnt_q == CW'(DW)) begin
          state_n = (state_q == ST_ADDR) ? ST_AACK : ST_DACK;
          cnt_n   = '0;
        end
      end
      ST_AACK, ST_DACK: begin
        if (scl_rise) begin
          acked_n = pull_q;
        end else if (scl_fall) begin
          if (state_q == ST_AACK) begin
            if (acked_q) begin
              hit_n   = 1'b1;
              dir_n   = sh_q[0];
              gc_n    = (sh_q[DW-1:1] == '0);
              state_n = sh_q[0] ? ST_SKIP : ST_DATA;
            end else begin
              state_n = ST_SKIP;
            end
          end else begin
            state_n = acked_q ? ST_DATA : ST_SKIP;
          end
        end
      end
      default: ;
    endcase
    if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      hit_n   = 1'b0;
      dir_n   = 1'b0;
      gc_n    = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      hit_n   = 1'b0;
      dir_n   = 1'b0;
      gc_n    = 1'b0;
    end
    // acknowledge level for the phase being entered or held
    if (!hw_en)                  ack_bit = host_ack;
    else if (state_n == ST_AACK) ack_bit = cmp_hit | gc_hit;
    else                         ack_bit = 1'b1;
    if (state_n == ST_AACK || state_n == ST_DACK)
      pull_n = scl_lvl ? pull_q : ack_bit;
    else
      pull_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      pull_q  <= 1'b0;
      acked_q <= 1'b0;
      hit_q   <= 1'b0;
      dir_q   <= 1'b0;
      gc_q    <= 1'b0;
      stb_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      pull_q  <= pull_n;
      acked_q <= acked_n;
      hit_q   <= hit_n;
      dir_q   <= dir_n;
      gc_q    <= gc_n;
      stb_q   <= stb_n;
      rdy_q   <= rdy_n;
    end
  end

  assign sda_pull  = pull_q;
  assign addr_hit  = hit_q;
  assign dir_read  = dir_q;
  assign gen_call  = gc_q;
  assign byte_rdy  = rdy_q;
  assign rx_strobe = stb_q;
  assign rx_byte   = sh_q;

  // R4
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_det || stop_det)) |-> $stable(pull_q));
  // R4
  pull_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    pull_q |-> (state_q == ST_AACK || state_q == ST_DACK));
  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    start_det |=> (state_q == ST_ADDR && cnt_q == '0 && !hit_q));
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    stop_det |=> (state_q == ST_IDLE && !hit_q));
  // R7
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    stb_q |-> (hit_q && !dir_q));
  // R5
  rdy_mode_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rdy_q |-> !$past(hw_en));
  // R8
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_SKIP) |-> (!pull_q && !stb_q));
endmodule

// File: tb/smb_addr_match_test.sv
`timescale 1ns/1ps
module smb_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       cfg_wr = 1'b0, cfg_sel = 1'b0, host_ack = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       sda_pull, addr_hit, dir_read, gen_call, byte_rdy, rx_strobe;
  logic [7:0] rx_byte;
  logic       sda_bus;

  int checks = 0, fails = 0, stb_cnt = 0, rdy_cnt = 0, cyc = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  smb_addr_match uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_pull(sda_pull),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .host_ack(host_ack),
    .addr_hit(addr_hit), .dir_read(dir_read), .gen_call(gen_call),
    .byte_rdy(byte_rdy), .rx_strobe(rx_strobe), .rx_byte(rx_byte));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_strobe) begin stb_cnt <= stb_cnt + 1; last_rx <= rx_byte; end
    if (byte_rdy) rdy_cnt <= rdy_cnt + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic hp; repeat (6) @(negedge clk); endtask

  task automatic cfg(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hp; scl_m = 1'b1; hp; sda_m = 1'b0; hp; scl_m = 1'b0; hp;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hp; scl_m = 1'b1; hp; sda_m = 1'b1; hp;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
    end
    sda_m = 1'b1; hp; scl_m = 1'b1;
    repeat (3) @(negedge clk);
    ack = !sda_bus;
    repeat (3) @(negedge clk);
    scl_m = 1'b0; hp;
  endtask

  initial begin
    logic ack;
    int s0, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "addr_hit after reset", addr_hit, 0);
    chk("R1", "sda_pull after reset", sda_pull, 0);
    chk("R1", "strobes after reset", rx_strobe | byte_rdy | gen_call | dir_read, 0);
    // R1 / R5: reset leaves host mode; host refuses, then accepts
    r0 = rdy_cnt;
    host_ack = 1'b0;
    bus_start; send(8'hA4, ack);
    chk("R1", "reset host-mode nack", ack, 0);
    chk("R5", "byte_rdy on address", rdy_cnt - r0, 1);
    bus_stop;
    host_ack = 1'b1;
    bus_start; send(8'hA4, ack);
    chk("R5", "host ack on unmatched address", ack, 1);
    chk("R6", "addr_hit after host ack", addr_hit, 1);
    bus_stop;
    host_ack = 1'b0;
    // R1: enable auto with full mask; reset address 0 and gc off
    cfg(1'b1, 8'hFF);
    bus_start; send(8'h00, ack);
    chk("R3", "field 0 refused, gc off", ack, 0);
    bus_stop;
    bus_start; send(8'h02, ack);
    chk("R1", "reset address 0 rejects 0x01", ack, 0);
    bus_stop;

    // R7 automatic write with data
    cfg(1'b0, 8'h5A); cfg(1'b1, 8'hFF);
    bus_start; send({7'h5A, 1'b0}, ack);
    chk("R2", "exact match ack", ack, 1);
    s0 = stb_cnt;
    send(8'hC3, ack);
    chk("R7", "data ack", ack, 1);
    chk("R7", "strobe count", stb_cnt - s0, 1);
    chk("R7", "rx_byte", last_rx, 8'hC3);
    chk("R4", "pull released after ninth fall", sda_pull, 0);
    send(8'h3C, ack);
    chk("R7", "second rx_byte", last_rx, 8'h3C);
    bus_stop;
    chk("R9", "stop clears addr_hit", addr_hit, 0);

    // R9 repeated start to another address
    bus_start; send({7'h5A, 1'b0}, ack);
    bus_start; send({7'h22, 1'b0}, ack);
    chk("R9", "repeated start nack", ack, 0);
    chk("R9", "addr_hit cleared by restart", addr_hit, 0);
    s0 = stb_cnt;
    send(8'h55, ack);
    chk("R8", "ignored byte not acked", ack, 0);
    chk("R8", "ignored byte no strobe", stb_cnt - s0, 0);
    bus_stop;

    // R10 read direction
    bus_start; send({7'h5A, 1'b1}, ack);
    chk("R10", "read address ack", ack, 1);
    chk("R6", "dir_read", dir_read, 1);
    s0 = stb_cnt;
    send(8'hFF, ack);
    chk("R10", "no ack in read phase", ack, 0);
    chk("R10", "no strobe in read phase", stb_cnt - s0, 0);
    bus_stop;

    // R5 host mode data refusal
    cfg(1'b1, 8'h7F);
    host_ack = 1'b1;
    bus_start; send({7'h11, 1'b0}, ack);
    chk("R5", "host address ack", ack, 1);
    host_ack = 1'b0;
    s0 = stb_cnt; r0 = rdy_cnt;
    send(8'h96, ack);
    chk("R5", "host data nack", ack, 0);
    chk("R5", "byte_rdy on data", rdy_cnt - r0, 1);
    chk("R7", "host-mode data strobe", stb_cnt - s0, 1);
    chk("R7", "host-mode rx_byte", last_rx, 8'h96);
    host_ack = 1'b1;
    s0 = stb_cnt;
    send(8'h69, ack);
    chk("R8", "after refusal no ack", ack, 0);
    chk("R8", "after refusal no strobe", stb_cnt - s0, 0);
    bus_stop;

    // sweep over all addresses under four configurations
    for (int c = 0; c < 4; c++) begin
      logic [6:0] slv, msk;
      logic       gce, hwe;
      case (c)
        0:       begin slv = 7'h5A; msk = 7'h7F; gce = 1'b0; hwe = 1'b1; end
        1:       begin slv = 7'h50; msk = 7'h70; gce = 1'b1; hwe = 1'b1; end
        2:       begin slv = 7'h33; msk = 7'h0C; gce = 1'b0; hwe = 1'b1; end
        default: begin slv = 7'h2B; msk = 7'h7F; gce = 1'b1; hwe = 1'b0; end
      endcase
      cfg(1'b0, {gce, slv});
      cfg(1'b1, {hwe, msk});
      r0 = rdy_cnt;
      for (int a = 0; a < 128; a++) begin
        logic rw, ea;
        rw = a[0] ^ a[3];
        host_ack = a[1] ^ a[4];
        if (hwe)
          ea = ((a != 0) && (((a[6:0] ^ slv) & msk) == 7'h00)) || (gce && a == 0);
        else
          ea = host_ack;
        bus_start;
        send({a[6:0], rw}, ack);
        chk(hwe ? ((a == 0) ? "R3" : "R2") : "R5", $sformatf("ack addr %0h cfg %0d", a, c), ack, ea);
        chk("R6", "addr_hit", addr_hit, ea);
        if (ea) begin
          chk("R6", "dir_read", dir_read, rw);
          chk("R6", "gen_call", gen_call, (a == 0));
        end
        bus_stop;
        chk("R9", "addr_hit after stop", addr_hit, 0);
      end
      chk("R5", "byte_rdy count per sweep", rdy_cnt - r0, hwe ? 0 : 128);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(negedge clk) begin
    if (!done && cyc > 190000) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule